// File: doc/BRIEF.md
# Receive Lock Status Monitor

This block decides when a clock-and-data-recovery receiver should report that it has lost lock, and when the receiver's output clock should be taken from the reference instead of the recovered clock. It runs entirely on a fast system clock. It samples the reference clock, the recovered clock, a loss-of-signal flag and a lock-to-reference mode control through two-flop synchronizers, and turns the two clocks into edge strobes.

Frequency is checked over windows of `WINDOW` reference edges. The block counts the recovered-clock edges that fall inside each window and compares the count with `WINDOW`. A deviation larger than a programmable tolerance marks the window bad. Lock is declared only after two consecutive good windows. A reference that shows no edge for `MISS_LIMIT` system cycles is treated as missing. The loss-of-signal alarm forces loss of lock only when lock-to-reference mode is off. In the usual configuration the alarm is wired straight onto the mode control, so that during signal loss the output clock is held to the reference.

Top module: `rx_lock_monitor`

## Requirements
- R1: During and directly after reset, `lossOfLock` is 1 and `refSelect` is 0.
- R2: A window closes on every `WINDOW`-th reference edge. It is good when |recovered edges in the window − `WINDOW`| ≤ `tolerance`, and bad otherwise. The `tolerance` input is `$clog2(WINDOW)+3` bits wide.
- R3: Once a bad window closes, `lossOfLock` is 1 from the next cycle on, until lock is regained.
- R4: `lossOfLock` can only clear after two consecutive good windows. A single good window after a bad one leaves it at 1.
- R5: When no reference edge is seen for `MISS_LIMIT` system cycles, `lossOfLock` is 1 whatever the mode. The window progress is discarded, so two fresh good windows are needed once the reference returns.
- R6: While lock-to-reference mode is off, an active loss-of-signal input forces `lossOfLock` to 1. While the mode is on, that input has no effect on `lossOfLock`.
- R7: `refSelect` follows the lock-to-reference mode input (1 = the output clock comes from the reference).
- R8: A level change on `losIn` or `ltrMode`, applied between clock edges, reaches the outputs on the third rising `sysClk` edge: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock, faster than twice either monitored clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Reference clock, sampled as data |
| recClk | input | 1 | Recovered clock, sampled as data |
| losIn | input | 1 | Loss-of-signal alarm, active high |
| ltrMode | input | 1 | Lock-to-reference mode select, active high |
| tolerance | input | $clog2(WINDOW)+3 | Largest allowed count deviation per window |
| lossOfLock | output | 1 | Loss-of-lock flag, active high |
| refSelect | output | 1 | Output clock source select, 1 = reference |

## Verification
The bench goes after the hysteresis edge. It checks that the flag is still set one and a half windows after the clocks come back into line. A design that cleared after a single good window would drop the flag there. It stops the reference and checks the flag both before and after the missing limit, then checks that lock needs two fresh windows afterwards. A detector that fired early, or that kept stale window credit, would show at one of those points. It raises the tolerance above a known deviation and expects lock to hold, which catches an inverted or off-by-one comparison. It also drives the alarm with the mode on and off, including the tied configuration, and counts the exact edges of synchronizer latency. This catches a design that lets the alarm override lock-to-reference mode, or that adds or drops a pipeline stage.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

  typedef struct packed {
    logic clearWindow;
  } dpStrobes_t;

  typedef struct packed {
    logic windowDone;
    logic windowBad;
    logic refMissing;
  } dpStatus_t;

  typedef enum logic [1:0] {
    LK_LOST     = 2'd0,
    LK_ONE_GOOD = 2'd1,
    LK_LOCKED   = 2'd2
  } lockState_t;

endpackage

// File: rtl/lockmon_sync.sv
module lockmon_sync #(
  parameter int WIDTH = 1
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/lockmon_datapath.sv
module lockmon_datapath
  import lockmon_pkg::*;
#(
  parameter int WINDOW     = 4096,
  parameter int MISS_LIMIT = 256,
  parameter int CNT_W      = $clog2(WINDOW) + 3
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             refLvl,
  input  logic             recLvl,
  input  logic [CNT_W-1:0] tolerance,
  input  dpStrobes_t       strobes,
  output dpStatus_t        status
);
  localparam int REF_W  = $clog2(WINDOW);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  logic              refPrev, recPrev;
  logic              refEdge, recEdge;
  logic [REF_W-1:0]  refCnt;
  logic [CNT_W-1:0]  recCnt;
  logic [MISS_W-1:0] missCnt;
  logic              lastRef;
  logic [CNT_W:0]    recTotal;
  logic [CNT_W:0]    deviation;

  assign refEdge = refLvl & ~refPrev;
  assign recEdge = recLvl & ~recPrev;
  assign lastRef = refEdge && (refCnt == REF_W'(WINDOW - 1));

  // Count including an edge that lands on the closing cycle
  assign recTotal  = {1'b0, recCnt} + (CNT_W + 1)'(recEdge);
  assign deviation = (recTotal >= (CNT_W + 1)'(WINDOW))
                   ? recTotal - (CNT_W + 1)'(WINDOW)
                   : (CNT_W + 1)'(WINDOW) - recTotal;

  assign status.windowDone = lastRef & ~strobes.clearWindow;
  assign status.windowBad  = deviation > {1'b0, tolerance};
  assign status.refMissing = (missCnt == MISS_W'(MISS_LIMIT));

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      recPrev <= 1'b0;
    end else begin
      refPrev <= refLvl;
      recPrev <= recLvl;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      recCnt <= '0;
    end else if (strobes.clearWindow || lastRef) begin
      refCnt <= '0;
      recCnt <= '0;
    end else begin
      if (refEdge) refCnt <= refCnt + 1'b1;
      if (recEdge && (recCnt != '1)) recCnt <= recCnt + 1'b1;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                             missCnt <= '0;
    else if (refEdge)                      missCnt <= '0;
    else if (missCnt != MISS_W'(MISS_LIMIT)) missCnt <= missCnt + 1'b1;
  end

  // R2: a closed window always starts the next one from zero
  p_window_wrap_r2: assert property (@(posedge sysClk) disable iff (!rstN)
    status.windowDone |=> (refCnt == '0));

  // R5: the missing detector holds its state until a reference edge shows up
  p_miss_hold_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    (status.refMissing && !refEdge) |=> status.refMissing);
endmodule

// File: rtl/lockmon_control.sv
module lockmon_control
  import lockmon_pkg::*;
(
  input  logic       sysClk,
  input  logic       rstN,
  input  dpStatus_t  status,
  input  logic       losS,
  input  logic       ltrS,
  output dpStrobes_t strobes,
  output logic       lossOfLock,
  output logic       refSelect
);
  lockState_t state, stateNext;

  assign strobes.clearWindow = status.refMissing;

  always_comb begin
    stateNext = state;
    if (status.refMissing) begin
      stateNext = LK_LOST;
    end else if (status.windowDone) begin
      if (status.windowBad) begin
        stateNext = LK_LOST;
      end else begin
        case (state)
          LK_LOST:     stateNext = LK_ONE_GOOD;
          LK_ONE_GOOD: stateNext = LK_LOCKED;
          default:     stateNext = LK_LOCKED;
        endcase
      end
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      state      <= LK_LOST;
      lossOfLock <= 1'b1;
      refSelect  <= 1'b0;
    end else begin
      state      <= stateNext;
      lossOfLock <= status.refMissing || (stateNext != LK_LOCKED) || (losS && !ltrS);
      refSelect  <= ltrS;
    end
  end

  // R6: alarm outside lock-to-reference mode forces the flag
  p_los_forces_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    (losS && !ltrS) |=> lossOfLock);

  // R7: mode select reaches the output clock select
  p_refsel_follows_r7: assert property (@(posedge sysClk) disable iff (!rstN)
    ltrS |=> refSelect);

  // R3: a bad window drops the lock state
  p_bad_window_r3: assert property (@(posedge sysClk) disable iff (!rstN)
    (status.windowDone && status.windowBad && !status.refMissing)
      |=> (lossOfLock && state == LK_LOST));

  // R4: the locked state is entered only from the one-good-window state
  p_two_good_r4: assert property (@(posedge sysClk) disable iff (!rstN)
    (state == LK_LOCKED && $past(state) != LK_LOCKED) |-> ($past(state) == LK_ONE_GOOD));

  // R5: a missing reference keeps the flag set
  p_missing_flag_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    status.refMissing |=> lossOfLock);
endmodule

// File: rtl/rx_lock_monitor.sv
module rx_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int WINDOW     = 4096,
  parameter int MISS_LIMIT = 256,
  localparam int CNT_W     = $clog2(WINDOW) + 3
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             refClk,
  input  logic             recClk,
  input  logic             losIn,
  input  logic             ltrMode,
  input  logic [CNT_W-1:0] tolerance,
  output logic             lossOfLock,
  output logic             refSelect
);
  logic [3:0] syncBus;
  dpStrobes_t strobes;
  dpStatus_t  status;

  lockmon_sync #(.WIDTH(4)) u_sync (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .asyncIn ({ltrMode, losIn, recClk, refClk}),
    .syncOut (syncBus)
  );

  lockmon_datapath #(
    .WINDOW     (WINDOW),
    .MISS_LIMIT (MISS_LIMIT),
    .CNT_W      (CNT_W)
  ) u_dp (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .refLvl    (syncBus[0]),
    .recLvl    (syncBus[1]),
    .tolerance (tolerance),
    .strobes   (strobes),
    .status    (status)
  );

  lockmon_control u_ctl (
    .sysClk     (sysClk),
    .rstN       (rstN),
    .status     (status),
    .losS       (syncBus[2]),
    .ltrS       (syncBus[3]),
    .strobes    (strobes),
    .lossOfLock (lossOfLock),
    .refSelect  (refSelect)
  );
endmodule

// File: tb/sim_rx_lock_monitor.sv
module sim_rx_lock_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 64;
  localparam int MISS       = 32;
  localparam int TOL_W      = $clog2(WIN) + 3;
  localparam int WIN_CYC    = WIN * 8;  // reference period is 8 system cycles

  logic sysClk = 1'b0, rstN = 1'b0;
  logic refRaw = 1'b0, refEn = 1'b1, recClk = 1'b0;
  logic losIn = 1'b0, ltrMode = 1'b0;
  logic [TOL_W-1:0] tolerance = TOL_W'(3);
  logic lossOfLock, refSelect;
  int   recHalf = 40;
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) sysClk = ~sysClk;
  always #40 refRaw = ~refRaw;
  initial forever begin
    #(recHalf);
    recClk = ~recClk;
  end

  rx_lock_monitor #(.WINDOW(WIN), .MISS_LIMIT(MISS)) u0 (
    .sysClk(sysClk), .rstN(rstN), .refClk(refRaw & refEn), .recClk(recClk),
    .losIn(losIn), .ltrMode(ltrMode), .tolerance(tolerance),
    .lossOfLock(lossOfLock), .refSelect(refSelect)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic t_reset;
    waitCyc(3);
    check("R1 lossOfLock in reset", lossOfLock, 1'b1);
    check("R1 refSelect in reset", refSelect, 1'b0);
    rstN = 1'b1;
    waitCyc(1);
    check("R1 lossOfLock after reset", lossOfLock, 1'b1);
    check("R1 refSelect after reset", refSelect, 1'b0);
  endtask

  task automatic t_first_lock;
    waitCyc(WIN_CYC * 3 / 2);
    check("R4 still lost before two windows", lossOfLock, 1'b1);
    waitCyc(WIN_CYC * 2);
    check("R2 locked with matched clocks", lossOfLock, 1'b0);
  endtask

  task automatic t_off_freq;
    recHalf = 45;  // about 57 edges per window, deviation 7 > 3
    waitCyc(WIN_CYC * 11 / 5);
    check("R3 bad window sets flag", lossOfLock, 1'b1);
    recHalf = 40;
    waitCyc(WIN_CYC * 3 / 2);
    check("R4 one good window is not enough", lossOfLock, 1'b1);
    waitCyc(WIN_CYC * 2);
    check("R4 relock after two good windows", lossOfLock, 1'b0);
  endtask

  task automatic t_tolerance;
    tolerance = TOL_W'(10);
    recHalf = 45;
    waitCyc(WIN_CYC * 7 / 2);
    check("R2 deviation within wider tolerance", lossOfLock, 1'b0);
    recHalf = 40;
    waitCyc(WIN_CYC * 2);
    tolerance = TOL_W'(3);
    waitCyc(WIN_CYC * 2);
    check("R2 matched clocks under tight tolerance", lossOfLock, 1'b0);
  endtask

  task automatic t_ref_missing;
    @(negedge sysClk) refEn = 1'b0;
    waitCyc(20);
    check("R5 flag clear before missing limit", lossOfLock, 1'b0);
    waitCyc(30);
    check("R5 missing reference sets flag", lossOfLock, 1'b1);
    refEn = 1'b1;
    waitCyc(WIN_CYC * 3 / 2);
    check("R5 window credit discarded", lossOfLock, 1'b1);
    waitCyc(WIN_CYC * 2);
    check("R5 relock after reference returns", lossOfLock, 1'b0);
  endtask

  task automatic t_los;
    @(negedge sysClk) losIn = 1'b1;
    waitCyc(2);
    check("R8 alarm not visible after two edges", lossOfLock, 1'b0);
    waitCyc(1);
    check("R6 alarm forces flag on third edge", lossOfLock, 1'b1);
    losIn = 1'b0;
    waitCyc(4);
    check("R6 flag clears with alarm gone", lossOfLock, 1'b0);
  endtask

  task automatic t_ltr;
    @(negedge sysClk) ltrMode = 1'b1;
    waitCyc(2);
    check("R8 select not visible after two edges", refSelect, 1'b0);
    waitCyc(1);
    check("R7 select follows mode", refSelect, 1'b1);
    losIn = 1'b1;  // tied configuration: alarm and mode both high
    waitCyc(6);
    check("R6 alarm ignored in lock-to-reference mode", lossOfLock, 1'b0);
    check("R7 select held during alarm", refSelect, 1'b1);
    refEn = 1'b0;
    waitCyc(60);
    check("R5 missing reference flags even in mode", lossOfLock, 1'b1);
    refEn = 1'b1;
    losIn = 1'b0;
    ltrMode = 1'b0;
    waitCyc(4);
    check("R7 select returns to recovered clock", refSelect, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_lock();
    t_off_freq();
    t_tolerance();
    t_ref_missing();
    t_los();
    t_ltr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule